// File: doc/BRIEF.md
# Length-Sequenced I2C Word Transfer Engine

This block runs one I2C controller transaction at the byte-command level and moves payload through a 32-bit data word instead of single bytes. Software writes a 7-bit target address, a direction bit, an 8-bit byte count and a count-enable bit in a single strobe. The engine then asks a byte-level bus engine for a START, sends the address byte, and streams data bytes out of, or into, the 32-bit word, least significant byte first.

When the count is enabled the engine counts the bytes down. It NACKs the final read byte by itself and issues the STOP by itself. A target that NACKs a written byte too early makes the engine stop at once and report a length error. When the count is disabled the engine pauses at every word boundary. Software then refills or drains the word, or requests a STOP. Software sees one interrupt pulse per 32-bit word, plus one for a partial final word.

The bus engine side is a simple command handshake. The engine holds a command with its valid bit until the bus engine returns a one-cycle done pulse. With that pulse come the received byte or the target's acknowledge. Bit timing on the wires and arbitration belong to the bus engine.

Top module: `i2c_word_xfer`

## Requirements
- R1: A strobe on `sw_addr_wr` while idle makes `busy` high from the next cycle on. The engine then issues START (command code 1), followed by a WRITE (code 2) of the byte {address[6:0], read bit}. `busy` falls only in the cycle after the done pulse of a STOP (code 4).
- R2: An address strobe while `busy` is high is ignored: the transaction in progress keeps its address, direction and count.
- R3: With count enable set, exactly `sw_len` data bytes (0 to 255) follow the address, and then a STOP is issued without software action. A count of 0 gives START, address, STOP.
- R4: Written bytes come from the data word with bits 7:0 first and bits 31:24 last. Before each group of four bytes the engine waits, with no command valid, until software has written a word with `sw_data_wr`.
- R5: Received bytes fill the read word with the first byte in bits 7:0. A final partial word has zeros in its unfilled upper bytes. `sw_rdata` holds the word while `irq_rd_word` is high.
- R6: `irq_wr_word` or `irq_rd_word` pulses for one cycle after every fourth byte of a word. It also pulses after the last counted byte when the count is not a multiple of 4.
- R7: Read acknowledge (`bus_nack_out`, 1 = NACK): the last counted byte gets NACK. In stretch mode the fourth byte of each word takes `sw_ack_action`. Every other byte gets ACK. A NACKed read byte is followed directly by STOP.
- R8: A target NACK on the address or on a written byte, while counted bytes would still remain after it, leads straight to STOP. It sets `len_err`, which stays set until the next accepted address strobe, and pulses `irq_err` once. Without count enable, a NACK also stops the transaction and pulses `irq_err`, but `len_err` stays 0.
- R9: Without count enable, the engine waits at each word boundary for `sw_data_wr` (write) or `sw_data_rd` (read). A `sw_stop` pulse makes it issue STOP at the next boundary. `sw_stop` has no effect when count enable is set.
- R10: After reset `busy`, `len_err`, all interrupts and `bus_cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr_wr | input | 1 | Strobe: start a transaction with the fields below |
| sw_addr | input | 7 | Target address |
| sw_read | input | 1 | 1 = read transaction, 0 = write |
| sw_len | input | 8 | Data byte count |
| sw_len_en | input | 1 | Enables the byte count |
| sw_stretch | input | 1 | Clock-stretch mode: `sw_ack_action` applies to each fourth read byte |
| sw_ack_action | input | 1 | Software acknowledge choice, 1 = NACK |
| sw_data_wr | input | 1 | Strobe: load the transmit word |
| sw_wdata | input | 32 | Transmit word |
| sw_data_rd | input | 1 | Strobe: software has taken the read word |
| sw_stop | input | 1 | Strobe: request STOP at the next word boundary (no count) |
| sw_rdata | output | 32 | Last completed read word |
| busy | output | 1 | Transaction in progress |
| len_err | output | 1 | Early target NACK under byte count |
| irq_wr_word | output | 1 | One-cycle pulse: write word sent |
| irq_rd_word | output | 1 | One-cycle pulse: read word ready |
| irq_err | output | 1 | One-cycle pulse: target NACK ended the transaction |
| bus_cmd_valid | output | 1 | Command to the byte engine is valid |
| bus_cmd | output | 3 | 1 start, 2 write byte, 3 read byte, 4 stop |
| bus_tx_byte | output | 8 | Byte to send with a write command |
| bus_nack_out | output | 1 | Acknowledge to send after a read byte, 1 = NACK |
| bus_done | input | 1 | One-cycle pulse: current command finished |
| bus_rx_byte | input | 8 | Received byte, valid with `bus_done` |
| bus_nack_in | input | 1 | Target NACKed the written byte, valid with `bus_done` |

## Verification
The embedded assertions watch the following on every cycle:
- `busy` ends only on a completed STOP.
- Address and direction stay fixed while busy.
- The count never goes below zero.
- A read word is never started while the previous one is still undrained.
- A last counted read byte is always NACKed.
- Any NACKed read byte or error is followed by STOP.

The full command sequence is checked only by the bench's scenarios, against an expected list kept in a scoreboard. This covers byte order, per-word interrupt counts, stalls for data, partial-word contents, the stretch-mode acknowledge choice, and that stray strobes are ignored.

// File: rtl/lx_pkg.sv
package lx_pkg;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_START = 3'd1,
    BC_WRITE = 3'd2,
    BC_READ  = 3'd3,
    BC_STOP  = 3'd4
  } bus_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_NEXT, S_WRB, S_RDB, S_STOP
  } seq_st_e;

  // A byte closes its word when it fills the last lane or is the final counted byte.
  function automatic logic word_done(input int lane, input int last_lane,
                                     input logic limited, input int remaining);
    return (lane == last_lane) || (limited && remaining == 1);
  endfunction

  // Acknowledge to return after a read byte; 1 means NACK.
  function automatic logic read_nack(input logic limited, input int remaining,
                                     input logic stretch, input logic sw_choice,
                                     input int lane, input int last_lane);
    if (limited && remaining == 1) return 1'b1;
    if (stretch && lane == last_lane) return sw_choice;
    return 1'b0;
  endfunction

endpackage

// File: rtl/lx_len_counter.sv
module lx_len_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             load_lim,
  input  logic             dec,
  output logic             limited,
  output logic [LEN_W-1:0] remaining,
  output logic             exhausted,
  output logic             last_one
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limited   <= 1'b0;
      remaining <= '0;
    end else if (load) begin
      limited   <= load_lim;
      remaining <= load_val;
    end else if (dec && limited && remaining != '0) begin
      remaining <= remaining - 1'b1;
    end
  end

  assign exhausted = limited && (remaining == '0);
  assign last_one  = limited && (remaining == LEN_W'(1));

  // R3: a counted transfer never moves a byte beyond the programmed count
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && limited) |-> (remaining != '0));

endmodule

// File: rtl/lx_word_pack.sv
module lx_word_pack #(
  parameter  int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sw_load,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_drain,
  input  logic              step,
  input  logic              word_end,
  input  logic              is_read,
  input  logic [7:0]        rx_byte,
  output logic [IDX_W-1:0]  lane,
  output logic [7:0]        tx_byte,
  output logic              tx_full,
  output logic              rd_full,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_acc;
  logic [DATA_W-1:0] merged;

  assign tx_byte = tx_word[8*lane +: 8];
  assign merged  = rx_acc | (DATA_W'(rx_byte) << (8*lane));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane    <= '0;
      tx_word <= '0;
      tx_full <= 1'b0;
      rx_acc  <= '0;
      rd_full <= 1'b0;
      rdata   <= '0;
    end else begin
      if (clear)     lane <= '0;
      else if (step) lane <= word_end ? '0 : lane + 1'b1;

      if (sw_load) begin
        tx_word <= sw_wdata;
        tx_full <= 1'b1;
      end else if (step && word_end && !is_read) begin
        tx_full <= 1'b0;
      end

      if (clear) begin
        rx_acc  <= '0;
        rd_full <= 1'b0;
      end else if (step && is_read) begin
        rx_acc <= word_end ? '0 : merged;
        if (word_end) begin
          rdata   <= merged;
          rd_full <= 1'b1;
        end
      end else if (sw_drain) begin
        rd_full <= 1'b0;
      end
    end
  end

  // R5: a fresh read word only starts once software has drained the previous one
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_read && lane == '0) |-> !rd_full);

  // R4: the first byte of a write word is only sent from a loaded word
  a_r4_word_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !is_read && lane == '0) |-> tx_full);

endmodule

// File: rtl/lx_seq_fsm.sv
module lx_seq_fsm
  import lx_pkg::*;
#(
  parameter  int LEN_W  = 8,
  parameter  int ADDR_W = 7,
  parameter  int BYTES  = 4,
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic              sw_read,
  input  logic              sw_stretch,
  input  logic              sw_ack_action,
  input  logic              sw_stop,
  input  logic              limited,
  input  logic [LEN_W-1:0]  remaining,
  input  logic              exhausted,
  input  logic              last_one,
  input  logic [IDX_W-1:0]  lane,
  input  logic [7:0]        tx_byte,
  input  logic              tx_full,
  input  logic              rd_full,
  input  logic              bus_done,
  input  logic              bus_nack_in,
  output logic              accept,
  output logic              step,
  output logic              word_end,
  output logic              is_read,
  output logic              busy,
  output logic              len_err,
  output logic              irq_wr_word,
  output logic              irq_rd_word,
  output logic              irq_err,
  output logic              bus_cmd_valid,
  output logic [2:0]        bus_cmd,
  output logic [7:0]        bus_tx_byte,
  output logic              bus_nack_out
);

  seq_st_e           st;
  bus_cmd_e          cmd;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_mode;
  logic              stop_req;
  logic              nack_q;

  assign accept   = (st == S_IDLE) && sw_addr_wr;
  assign step     = bus_done && (st == S_WRB || st == S_RDB);
  assign word_end = word_done(int'(lane), BYTES - 1, limited, int'(remaining));
  assign is_read  = rd_mode;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      addr_q      <= '0;
      rd_mode     <= 1'b0;
      stop_req    <= 1'b0;
      nack_q      <= 1'b0;
      len_err     <= 1'b0;
      irq_wr_word <= 1'b0;
      irq_rd_word <= 1'b0;
      irq_err     <= 1'b0;
    end else begin
      irq_wr_word <= 1'b0;
      irq_rd_word <= 1'b0;
      irq_err     <= 1'b0;
      if (sw_stop && busy && !limited) stop_req <= 1'b1;
      case (st)
        S_IDLE: if (sw_addr_wr) begin
          st       <= S_START;
          addr_q   <= sw_addr;
          rd_mode  <= sw_read;
          stop_req <= 1'b0;
          len_err  <= 1'b0;
        end
        S_START: if (bus_done) st <= S_ADDR;
        S_ADDR: if (bus_done) begin
          if (bus_nack_in) begin
            irq_err <= 1'b1;
            len_err <= limited && !exhausted;
            st      <= S_STOP;
          end else begin
            st <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (exhausted) begin
            st <= S_STOP;
          end else if (lane == '0 && stop_req) begin
            st <= S_STOP;
          end else if (rd_mode) begin
            if (lane != '0 || !rd_full) begin
              nack_q <= read_nack(limited, int'(remaining), sw_stretch,
                                  sw_ack_action, int'(lane), BYTES - 1);
              st     <= S_RDB;
            end
          end else if (lane != '0 || tx_full) begin
            st <= S_WRB;
          end
        end
        S_WRB: if (bus_done) begin
          if (bus_nack_in && !last_one) begin
            irq_err <= 1'b1;
            len_err <= limited;
            st      <= S_STOP;
          end else begin
            irq_wr_word <= word_end;
            st          <= S_NEXT;
          end
        end
        S_RDB: if (bus_done) begin
          irq_rd_word <= word_end;
          st          <= nack_q ? S_STOP : S_NEXT;
        end
        S_STOP: if (bus_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd          = BC_NONE;
    bus_tx_byte  = '0;
    bus_nack_out = 1'b0;
    case (st)
      S_START: cmd = BC_START;
      S_ADDR: begin
        cmd         = BC_WRITE;
        bus_tx_byte = 8'({addr_q, rd_mode});
      end
      S_WRB: begin
        cmd         = BC_WRITE;
        bus_tx_byte = tx_byte;
      end
      S_RDB: begin
        cmd          = BC_READ;
        bus_nack_out = nack_q;
      end
      S_STOP:  cmd = BC_STOP;
      default: cmd = BC_NONE;
    endcase
  end

  assign bus_cmd_valid = (cmd != BC_NONE);
  assign bus_cmd       = cmd;

  // R1: the transaction only ends on a finished STOP command
  a_r1_busy_ends_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bus_done && cmd == BC_STOP));

  // R2: address and direction cannot change while a transaction runs
  a_r2_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(rd_mode)));

  // R7: the last counted read byte is always NACKed
  a_r7_last_read_nacked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == BC_READ && last_one) |-> bus_nack_out);

  // R7: a NACKed read byte is followed by STOP
  a_r7_nack_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && cmd == BC_READ && bus_nack_out) |=> (cmd == BC_STOP));

  // R8: an error interrupt coincides with the STOP request
  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (cmd == BC_STOP));

  // R8: a length error only arises under an enabled count
  a_r8_lenerr_counted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_err) |-> limited);

  // R6: one word interrupt kind at a time
  a_r6_single_word_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_wr_word && irq_rd_word));

endmodule

// File: rtl/i2c_word_xfer.sv
module i2c_word_xfer #(
  parameter  int DATA_W = 32,
  parameter  int LEN_W  = 8,
  parameter  int ADDR_W = 7,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic              sw_read,
  input  logic [LEN_W-1:0]  sw_len,
  input  logic              sw_len_en,
  input  logic              sw_stretch,
  input  logic              sw_ack_action,
  input  logic              sw_data_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_data_rd,
  input  logic              sw_stop,
  output logic [DATA_W-1:0] sw_rdata,
  output logic              busy,
  output logic              len_err,
  output logic              irq_wr_word,
  output logic              irq_rd_word,
  output logic              irq_err,
  output logic              bus_cmd_valid,
  output logic [2:0]        bus_cmd,
  output logic [7:0]        bus_tx_byte,
  output logic              bus_nack_out,
  input  logic              bus_done,
  input  logic [7:0]        bus_rx_byte,
  input  logic              bus_nack_in
);

  logic             accept, step, word_end, is_read;
  logic             limited, exhausted, last_one;
  logic [LEN_W-1:0] remaining;
  logic [IDX_W-1:0] lane;
  logic [7:0]       tx_byte;
  logic             tx_full, rd_full;

  lx_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(sw_len),
    .load_lim(sw_len_en), .dec(step), .limited(limited),
    .remaining(remaining), .exhausted(exhausted), .last_one(last_one)
  );

  lx_word_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sw_load(sw_data_wr),
    .sw_wdata(sw_wdata), .sw_drain(sw_data_rd), .step(step),
    .word_end(word_end), .is_read(is_read), .rx_byte(bus_rx_byte),
    .lane(lane), .tx_byte(tx_byte), .tx_full(tx_full),
    .rd_full(rd_full), .rdata(sw_rdata)
  );

  lx_seq_fsm #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_addr_wr(sw_addr_wr), .sw_addr(sw_addr),
    .sw_read(sw_read), .sw_stretch(sw_stretch),
    .sw_ack_action(sw_ack_action), .sw_stop(sw_stop),
    .limited(limited), .remaining(remaining), .exhausted(exhausted),
    .last_one(last_one), .lane(lane), .tx_byte(tx_byte),
    .tx_full(tx_full), .rd_full(rd_full), .bus_done(bus_done),
    .bus_nack_in(bus_nack_in), .accept(accept), .step(step),
    .word_end(word_end), .is_read(is_read), .busy(busy),
    .len_err(len_err), .irq_wr_word(irq_wr_word),
    .irq_rd_word(irq_rd_word), .irq_err(irq_err),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd),
    .bus_tx_byte(bus_tx_byte), .bus_nack_out(bus_nack_out)
  );

endmodule

// File: tb/tb_i2c_word_xfer.sv
module tb_i2c_word_xfer;

  localparam logic [2:0] C_START = 3'd1, C_WRITE = 3'd2, C_READ = 3'd3, C_STOP = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_addr_wr = 0, sw_read = 0, sw_len_en = 0, sw_stretch = 0;
  logic        sw_ack_action = 0, sw_data_wr = 0, sw_data_rd = 0, sw_stop = 0;
  logic [6:0]  sw_addr = 0;
  logic [7:0]  sw_len = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] sw_rdata;
  logic        busy, len_err, irq_wr_word, irq_rd_word, irq_err;
  logic        bus_cmd_valid, bus_nack_out;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_tx_byte;
  logic        bus_done = 0, bus_nack_in = 0;
  logic [7:0]  bus_rx_byte = 0;

  always #10 clk = ~clk;

  i2c_word_xfer dut (
    .clk(clk), .rst_n(rst_n), .sw_addr_wr(sw_addr_wr), .sw_addr(sw_addr),
    .sw_read(sw_read), .sw_len(sw_len), .sw_len_en(sw_len_en),
    .sw_stretch(sw_stretch), .sw_ack_action(sw_ack_action),
    .sw_data_wr(sw_data_wr), .sw_wdata(sw_wdata), .sw_data_rd(sw_data_rd),
    .sw_stop(sw_stop), .sw_rdata(sw_rdata), .busy(busy), .len_err(len_err),
    .irq_wr_word(irq_wr_word), .irq_rd_word(irq_rd_word), .irq_err(irq_err),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_tx_byte(bus_tx_byte),
    .bus_nack_out(bus_nack_out), .bus_done(bus_done), .bus_rx_byte(bus_rx_byte),
    .bus_nack_in(bus_nack_in)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R10";
  logic [11:0] exp_q[$];
  int n_wr = 0, n_rd = 0, n_err = 0;
  int wr_cnt = 0, nack_at = -1;
  logic [7:0] rx_next = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // expected read acknowledge, restated from R7
  function automatic logic bench_ack(input bit counted, input int left,
                                     input bit stretch, input bit choice, input int pos);
    if (counted && left == 1) return 1'b1;
    if (stretch && (pos % 4) == 3) return choice;
    return 1'b0;
  endfunction

  task automatic push(input logic [2:0] c, input logic [7:0] b, input logic a);
    exp_q.push_back({c, b, a});
  endtask

  always @(negedge clk) begin
    n_wr  += int'(irq_wr_word);
    n_rd  += int'(irq_rd_word);
    n_err += int'(irq_err);
  end

  // bus engine model and scoreboard monitor
  initial begin
    logic [11:0] obs, expv;
    forever begin
      @(negedge clk);
      if (bus_done) begin
        bus_done    = 1'b0;
        bus_nack_in = 1'b0;
      end else if (bus_cmd_valid) begin
        obs = {bus_cmd, (bus_cmd == C_WRITE) ? bus_tx_byte : 8'h00,
               (bus_cmd == C_READ) ? bus_nack_out : 1'b0};
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected bus command", 32'(obs), 32'h0);
        end else begin
          expv = exp_q.pop_front();
          chk(obs == expv, cur_req, "bus command {cmd,byte,nack}", 32'(obs), 32'(expv));
        end
        repeat (2) @(negedge clk);
        if (bus_cmd == C_WRITE) begin
          wr_cnt++;
          bus_nack_in = (wr_cnt == nack_at);
        end
        if (bus_cmd == C_READ) begin
          bus_rx_byte = rx_next;
          rx_next     = rx_next + 8'd1;
        end
        bus_done = 1'b1;
      end
    end
  end

  task automatic load_word(input logic [31:0] w);
    sw_wdata = w; sw_data_wr = 1'b1;
    @(negedge clk); sw_data_wr = 1'b0;
  endtask

  task automatic begin_xfer(input logic [6:0] a, input bit rd, input logic [7:0] n,
                            input bit en, input string req);
    cur_req = req; wr_cnt = 0;
    sw_addr = a; sw_read = rd; sw_len = n; sw_len_en = en; sw_addr_wr = 1'b1;
    @(negedge clk); sw_addr_wr = 1'b0;
    chk(busy == 1'b1, "R1", "busy one cycle after address strobe", 32'(busy), 32'h1);
  endtask

  task automatic wait_idle(input string req);
    int guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    chk(!busy, "R1", "busy returned low after STOP", 32'(busy), 32'h0);
    chk(exp_q.size() == 0, req, "all expected commands issued", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
  endtask

  task automatic wait_wr_irq();
    do @(negedge clk); while (!irq_wr_word);
  endtask

  task automatic wait_rd_irq();
    do @(negedge clk); while (!irq_rd_word);
  endtask

  initial begin
    int b_wr, b_rd, b_err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10", "busy after reset", 32'(busy), 0);
    chk(bus_cmd_valid == 0, "R10", "cmd valid after reset", 32'(bus_cmd_valid), 0);
    chk(len_err == 0 && irq_err == 0, "R10", "error flags after reset", 32'({len_err, irq_err}), 0);

    // R4 R6 R2 R9: counted write of 6 bytes, second word stalls for data
    b_wr = n_wr;
    push(C_START, 0, 0); push(C_WRITE, 8'hA0, 0);
    push(C_WRITE, 8'h11, 0); push(C_WRITE, 8'h22, 0);
    push(C_WRITE, 8'h33, 0); push(C_WRITE, 8'h44, 0);
    push(C_WRITE, 8'h55, 0); push(C_WRITE, 8'h66, 0); push(C_STOP, 0, 0);
    load_word(32'h44332211);
    begin_xfer(7'h50, 1'b0, 8'd6, 1'b1, "R4");
    wait_wr_irq();
    repeat (4) @(negedge clk);
    chk(bus_cmd_valid == 0, "R4", "engine waits for next word", 32'(bus_cmd_valid), 0);
    cur_req = "R2";
    sw_stop = 1'b1; sw_addr = 7'h22; sw_read = 1'b1; sw_addr_wr = 1'b1;
    @(negedge clk); sw_stop = 1'b0; sw_addr_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1 && bus_cmd_valid == 0, "R9", "stray stop/address strobe ignored",
        32'({busy, bus_cmd_valid}), 32'h2);
    load_word(32'h00006655);
    wait_idle("R3");
    chk(n_wr - b_wr == 2, "R6", "write word interrupts for 6 bytes", 32'(n_wr - b_wr), 2);
    chk(len_err == 0, "R8", "no length error on full write", 32'(len_err), 0);

    // R5 R7 R6: counted read of 5 bytes
    b_rd = n_rd; rx_next = 8'h30;
    push(C_START, 0, 0); push(C_WRITE, 8'hA1, 0);
    for (int i = 0; i < 5; i++) push(C_READ, 0, bench_ack(1, 5 - i, 0, 0, i));
    push(C_STOP, 0, 0);
    begin_xfer(7'h50, 1'b1, 8'd5, 1'b1, "R7");
    wait_rd_irq();
    chk(sw_rdata == 32'h33323130, "R5", "first read word", sw_rdata, 32'h33323130);
    sw_data_rd = 1'b1; @(negedge clk); sw_data_rd = 1'b0;
    wait_rd_irq();
    chk(sw_rdata == 32'h00000034, "R5", "partial final read word", sw_rdata, 32'h34);
    wait_idle("R7");
    chk(n_rd - b_rd == 2, "R6", "read word interrupts for 5 bytes", 32'(n_rd - b_rd), 2);

    // R3: count of zero
    b_wr = n_wr; b_rd = n_rd;
    push(C_START, 0, 0); push(C_WRITE, 8'hE0, 0); push(C_STOP, 0, 0);
    begin_xfer(7'h70, 1'b0, 8'd0, 1'b1, "R3");
    wait_idle("R3");
    chk((n_wr - b_wr) + (n_rd - b_rd) == 0, "R3", "no word interrupt at count 0",
        32'((n_wr - b_wr) + (n_rd - b_rd)), 0);

    // R8: target NACKs the second data byte of four
    b_wr = n_wr; b_err = n_err; nack_at = 3;
    push(C_START, 0, 0); push(C_WRITE, 8'hA0, 0);
    push(C_WRITE, 8'hAA, 0); push(C_WRITE, 8'hBB, 0); push(C_STOP, 0, 0);
    load_word(32'hDDCCBBAA);
    begin_xfer(7'h50, 1'b0, 8'd4, 1'b1, "R8");
    wait_idle("R8");
    nack_at = -1;
    chk(len_err == 1, "R8", "length error after early NACK", 32'(len_err), 1);
    chk(n_err - b_err == 1, "R8", "one error interrupt", 32'(n_err - b_err), 1);
    chk(n_wr - b_wr == 0, "R8", "no word interrupt on aborted word", 32'(n_wr - b_wr), 0);

    // R7 R9: uncounted stretch-mode read, software NACKs the eighth byte
    b_rd = n_rd; rx_next = 8'h60; sw_stretch = 1'b1; sw_ack_action = 1'b0;
    push(C_START, 0, 0); push(C_WRITE, 8'h55, 0);
    for (int i = 0; i < 4; i++) push(C_READ, 0, bench_ack(0, 0, 1, 0, i));
    for (int i = 4; i < 8; i++) push(C_READ, 0, bench_ack(0, 0, 1, 1, i));
    push(C_STOP, 0, 0);
    begin_xfer(7'h2A, 1'b1, 8'd0, 1'b0, "R7");
    chk(len_err == 0, "R8", "length error cleared by new transaction", 32'(len_err), 0);
    wait_rd_irq();
    chk(sw_rdata == 32'h63626160, "R5", "stretch read word 1", sw_rdata, 32'h63626160);
    repeat (3) @(negedge clk);
    chk(bus_cmd_valid == 0, "R9", "read waits for drain", 32'(bus_cmd_valid), 0);
    sw_ack_action = 1'b1; sw_data_rd = 1'b1; @(negedge clk); sw_data_rd = 1'b0;
    wait_rd_irq();
    chk(sw_rdata == 32'h67666564, "R5", "stretch read word 2", sw_rdata, 32'h67666564);
    wait_idle("R7");
    chk(n_rd - b_rd == 2, "R6", "stretch read word interrupts", 32'(n_rd - b_rd), 2);
    sw_stretch = 1'b0; sw_ack_action = 1'b0;

    // R9: uncounted write ended by software stop
    b_wr = n_wr;
    push(C_START, 0, 0); push(C_WRITE, 8'h20, 0);
    push(C_WRITE, 8'h01, 0); push(C_WRITE, 8'h02, 0);
    push(C_WRITE, 8'h03, 0); push(C_WRITE, 8'h04, 0); push(C_STOP, 0, 0);
    load_word(32'h04030201);
    begin_xfer(7'h10, 1'b0, 8'd9, 1'b0, "R9");
    wait_wr_irq();
    repeat (3) @(negedge clk);
    chk(bus_cmd_valid == 0 && busy == 1, "R9", "uncounted write waits at boundary",
        32'({busy, bus_cmd_valid}), 32'h2);
    sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
    wait_idle("R9");
    chk(n_wr - b_wr == 1, "R6", "one word interrupt before stop", 32'(n_wr - b_wr), 1);

    // R6 R7: counted read of exactly 4 bytes
    b_rd = n_rd; rx_next = 8'h90;
    push(C_START, 0, 0); push(C_WRITE, 8'h0F, 0);
    for (int i = 0; i < 4; i++) push(C_READ, 0, bench_ack(1, 4 - i, 0, 0, i));
    push(C_STOP, 0, 0);
    begin_xfer(7'h07, 1'b1, 8'd4, 1'b1, "R6");
    wait_rd_irq();
    chk(sw_rdata == 32'h93929190, "R5", "single full read word", sw_rdata, 32'h93929190);
    wait_idle("R6");
    chk(n_rd - b_rd == 1, "R6", "one interrupt for 4-byte read", 32'(n_rd - b_rd), 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule